// File: doc/BRIEF.md
# Modulo-Addressed Burst Mover

A single-channel mover that keeps a bank of small peripheral output buffers fed from a source memory. The buffers sit in a 16-byte destination window (four 32-bit slots by default). Each time the peripheral reports that its buffers are empty, it sends a one-cycle request, and the mover runs one minor loop: it fills every slot in the window once, then stops and waits for the next request. It counts minor loops down from a major count. When the last loop ends it raises `done` and ignores further requests.

Software gives a source base address, a length in bytes and a mode bit. These values are captured when the channel enable rises. A length of zero, or a length that is not a whole number of minor loops, is refused and `err` is set. In forward mode, words are read upward and written to window offsets 0, 4, 8, 12. In reverse mode, half-words are read downward from the top of each 16-byte block and packed in pairs. The packed words are written to offsets 12, 8, 4, 0. Word order is kept, and the two half-words of every word are swapped on the fly. The destination pointer is never reloaded between loops: it wraps inside the window by modulo arithmetic.

The source port has a fixed read latency of one cycle. Read data belongs to the read issued in the previous cycle.

Top module: `modbeat_dma`

## Requirements
- R1: While reset is asserted, and after it is released, `busy`, `done`, `err`, `src_rd` and `dst_we` are 0.
- R2: A rising edge of `ch_en`, with `cfg_len` nonzero and a multiple of 16, arms the channel with `done`=0 and `err`=0. No read happens until a request arrives.
- R3: In forward mode (`cfg_rev`=0), a request sampled at one clock edge produces four 32-bit reads (`src_half`=0) in the next four cycles. The first read is at the current source address. Each word is written one cycle after its read, unchanged, to window offsets 0, 4, 8, 12 in that order. Words are little-endian: bits [7:0] come from the lowest byte address.
- R4: `dst_addr` stays inside the 16-byte window and wraps by modulo. Every forward minor loop starts at offset 0 and every reverse loop at offset 12, with no reload between loops.
- R5: After each minor loop the source base for the next loop is 16 bytes higher, in both modes. Consecutive reads step by +4 in forward mode and by -2 in reverse mode.
- R6: After exactly `cfg_len`/16 minor loops, `done` is 1 and `busy` is 0 (for example, 153600 bytes give 9600 loops). Before that, `done` is 0. Requests made after completion cause no read.
- R7: In reverse mode (`cfg_rev`=1), each minor loop at base B reads half-words (`src_half`=1, data in bits [15:0]) at B+14, B+12, down to B+0. It writes window offset 4k with bits [31:16] set to the half-word at B+4k and bits [15:0] set to the half-word at B+4k+2, in the order k = 3, 2, 1, 0.
- R8: A request that arrives while a minor loop is running (`busy`=1) is ignored. It starts no extra loop and uses up no major count.
- R9: A zero length, or a length that is not a multiple of 16, sets `err`=1 and leaves the channel idle. Requests then cause no read. The next valid enable clears `err`.
- R10: Dropping `ch_en` abandons the transfer; `busy` is 0 from the next cycle on. A new rising edge reloads the source address, length and mode from the configuration inputs.
- R11: `dst_we` is asserted only while `busy` is 1. Reverse-mode writes are never in back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable; a rising edge captures the configuration |
| cfg_src | input | SRC_AW | Source byte address of the first minor loop |
| cfg_len | input | LEN_W | Transfer length in bytes |
| cfg_rev | input | 1 | 1 selects reverse half-word-swapping mode |
| req | input | 1 | Peripheral empty request, one cycle per minor loop |
| src_rd | output | 1 | Source read strobe |
| src_half | output | 1 | 1 for a 16-bit read, 0 for a 32-bit read |
| src_addr | output | SRC_AW | Source byte address |
| src_rdata | input | 32 | Read data, valid one cycle after `src_rd` |
| dst_we | output | 1 | Destination window write strobe |
| dst_addr | output | log2(4*NBUF) | Byte offset inside the destination window |
| dst_wdata | output | 32 | Destination write data |
| busy | output | 1 | A minor loop is running |
| done | output | 1 | All minor loops finished |
| err | output | 1 | Last enable carried an illegal length |

## Verification
The bench builds the block with its defaults: a 16-bit source address, a 20-bit length and four destination slots. The 20-bit length makes the 153600-byte, 9600-loop transfer reachable in a directed run. That run checks the major counter end to end, and the 16-bit source address wraps several times during it. The four-slot window lets both the forward wrap at 16 and the reverse wrap from 0 back to 12 occur many times. Random bases, modes and loop counts mix the two orderings around directed cases for illegal lengths, abandoned loops and requests made while busy.

// File: rtl/mdm_pkg.sv
package mdm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } mdm_state_e;

  localparam int WORD_BYTES = 4;
  localparam int HALF_BYTES = 2;

endpackage

// File: rtl/mdm_ctrl.sv
module mdm_ctrl
  import mdm_pkg::*;
#(
  parameter  int LEN_W    = 20,
  parameter  int NBUF     = 4,
  localparam int MINOR_SH = $clog2(NBUF * WORD_BYTES),
  localparam int MAJ_W    = LEN_W - MINOR_SH,
  localparam int HALF_N   = 2 * NBUF,
  localparam int BEAT_W   = $clog2(HALF_N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_en,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_rev,
  input  logic              req,
  output mdm_state_e        state_q,
  output logic [BEAT_W-1:0] beat_q,
  output logic              rev_q,
  output logic              start_ok,
  output logic              rd_go,
  output logic              minor_end,
  output logic              err_q
);

  logic              en_q;
  logic              start;
  logic              len_ok;
  logic              running;
  logic              last_minor;
  logic [BEAT_W-1:0] nreads;
  logic [MAJ_W-1:0]  maj_q, maj_d;
  logic              maj_en;
  logic [BEAT_W-1:0] beat_d;
  mdm_state_e        state_d;

  assign start      = ch_en & ~en_q;
  assign len_ok     = (cfg_len != '0) && (cfg_len[MINOR_SH-1:0] == '0);
  assign start_ok   = start & len_ok;
  assign running    = (state_q == ST_RUN);
  assign nreads     = rev_q ? BEAT_W'(HALF_N) : BEAT_W'(NBUF);
  assign rd_go      = running && (beat_q < nreads);
  assign minor_end  = running && (beat_q == nreads);
  assign last_minor = (maj_q == MAJ_W'(1));

  // next state
  always_comb begin
    state_d = state_q;
    if (!ch_en) begin
      state_d = ST_IDLE;
    end else if (start) begin
      state_d = len_ok ? ST_ARMED : ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ARMED: if (req)       state_d = ST_RUN;
        ST_RUN:   if (minor_end) state_d = last_minor ? ST_DONE : ST_ARMED;
        default:                 state_d = state_q;
      endcase
    end
  end

  // major count and beat count
  always_comb begin
    maj_en = start_ok | minor_end;
    maj_d  = maj_q;
    if (start_ok)       maj_d = cfg_len[LEN_W-1:MINOR_SH];
    else if (minor_end) maj_d = maj_q - MAJ_W'(1);
    beat_d = (running && !minor_end) ? beat_q + BEAT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      en_q    <= ch_en;
      beat_q  <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      maj_q <= '0;
    else if (maj_en) maj_q <= maj_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rev_q <= 1'b0;
    else if (start_ok) rev_q <= cfg_rev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     err_q <= 1'b0;
    else if (start) err_q <= ~len_ok;
  end

endmodule

// File: rtl/mdm_srcgen.sv
module mdm_srcgen
  import mdm_pkg::*;
#(
  parameter  int SRC_AW  = 16,
  parameter  int NBUF    = 4,
  localparam int MINOR_B = NBUF * WORD_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SRC_AW-1:0] cfg_src,
  input  logic              cfg_rev,
  input  logic              step,
  input  logic              minor_end,
  input  logic              rev_q,
  output logic [SRC_AW-1:0] addr_q
);

  logic [SRC_AW-1:0] addr_d;
  logic              addr_en;
  logic              rewind;

  // Reverse mode ends a loop two bytes below its base; jump to the top of the next block.
  assign rewind  = minor_end & rev_q;
  assign addr_en = load | step | rewind;

  always_comb begin
    addr_d = addr_q;
    if (load)
      addr_d = cfg_src + (cfg_rev ? SRC_AW'(MINOR_B - HALF_BYTES) : '0);
    else if (step)
      addr_d = rev_q ? addr_q - SRC_AW'(HALF_BYTES) : addr_q + SRC_AW'(WORD_BYTES);
    else if (rewind)
      addr_d = addr_q + SRC_AW'(2 * MINOR_B);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

endmodule

// File: rtl/mdm_pack.sv
module mdm_pack
  import mdm_pkg::*;
#(
  parameter  int NBUF     = 4,
  parameter  int BEAT_W   = 4,
  localparam int MINOR_B  = NBUF * WORD_BYTES,
  localparam int MINOR_SH = $clog2(MINOR_B)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                cfg_rev,
  input  logic                run,
  input  logic [BEAT_W-1:0]   beat,
  input  logic                rev_q,
  input  logic [31:0]         rdata,
  output logic                we,
  output logic [MINOR_SH-1:0] waddr,
  output logic [31:0]         wdata
);

  logic [15:0]         hold_q;
  logic                hold_en;
  logic [MINOR_SH-1:0] ptr_q, ptr_d;
  logic                ptr_en;

  // forward: every beat after the first writes; reverse: every even beat after the first
  assign we      = run && (beat != '0) && (!rev_q || !beat[0]);
  assign hold_en = run && rev_q && beat[0];
  assign waddr   = ptr_q;

  generate
    if (NBUF > 1) begin : g_swap
      assign wdata = rev_q ? {rdata[15:0], hold_q} : rdata;
    end else begin : g_flat
      assign wdata = rev_q ? {rdata[15:0], hold_q} : rdata;
    end
  endgenerate

  // destination pointer: modulo window, never reloaded between minor loops
  always_comb begin
    ptr_en = load | we;
    ptr_d  = ptr_q;
    if (load)    ptr_d = cfg_rev ? MINOR_SH'(MINOR_B - WORD_BYTES) : '0;
    else if (we) ptr_d = rev_q ? ptr_q - MINOR_SH'(WORD_BYTES) : ptr_q + MINOR_SH'(WORD_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= rdata[15:0];
  end

endmodule

// File: rtl/modbeat_dma.sv
module modbeat_dma
  import mdm_pkg::*;
#(
  parameter  int SRC_AW   = 16,
  parameter  int LEN_W    = 20,
  parameter  int NBUF     = 4,
  localparam int MINOR_SH = $clog2(NBUF * WORD_BYTES),
  localparam int BEAT_W   = $clog2(2 * NBUF + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ch_en,
  input  logic [SRC_AW-1:0]   cfg_src,
  input  logic [LEN_W-1:0]    cfg_len,
  input  logic                cfg_rev,
  input  logic                req,
  output logic                src_rd,
  output logic                src_half,
  output logic [SRC_AW-1:0]   src_addr,
  input  logic [31:0]         src_rdata,
  output logic                dst_we,
  output logic [MINOR_SH-1:0] dst_addr,
  output logic [31:0]         dst_wdata,
  output logic                busy,
  output logic                done,
  output logic                err
);

  mdm_state_e        state_q;
  logic [BEAT_W-1:0] beat_q;
  logic              rev_q;
  logic              start_ok;
  logic              rd_go;
  logic              minor_end;
  logic              err_q;

  mdm_ctrl #(.LEN_W(LEN_W), .NBUF(NBUF)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_en     (ch_en),
    .cfg_len   (cfg_len),
    .cfg_rev   (cfg_rev),
    .req       (req),
    .state_q   (state_q),
    .beat_q    (beat_q),
    .rev_q     (rev_q),
    .start_ok  (start_ok),
    .rd_go     (rd_go),
    .minor_end (minor_end),
    .err_q     (err_q)
  );

  mdm_srcgen #(.SRC_AW(SRC_AW), .NBUF(NBUF)) u_src (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_ok),
    .cfg_src   (cfg_src),
    .cfg_rev   (cfg_rev),
    .step      (rd_go),
    .minor_end (minor_end),
    .rev_q     (rev_q),
    .addr_q    (src_addr)
  );

  mdm_pack #(.NBUF(NBUF), .BEAT_W(BEAT_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start_ok),
    .cfg_rev (cfg_rev),
    .run     (busy),
    .beat    (beat_q),
    .rev_q   (rev_q),
    .rdata   (src_rdata),
    .we      (dst_we),
    .waddr   (dst_addr),
    .wdata   (dst_wdata)
  );

  assign src_rd   = rd_go;
  assign src_half = rd_go & rev_q;
  assign busy     = (state_q == ST_RUN);
  assign done     = (state_q == ST_DONE);
  assign err      = err_q;

endmodule

// File: rtl/mdm_checker.sv
module mdm_checker #(
  parameter int SRC_AW   = 16,
  parameter int MINOR_SH = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ch_en,
  input logic                busy,
  input logic                done,
  input logic                err,
  input logic                src_rd,
  input logic [SRC_AW-1:0]   src_addr,
  input logic                dst_we,
  input logic [MINOR_SH-1:0] dst_addr,
  input logic                rev_q
);

  // R11
  a_r11_write_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> busy);

  // R11
  a_r11_rev_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && rev_q) |-> !$past(dst_we));

  // R2
  a_r2_read_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    src_rd |-> busy);

  // R6
  a_r6_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !src_rd && !dst_we));

  // R6
  a_r6_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R9
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && !done));

  // R5
  a_r5_src_step: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && $past(src_rd)) |->
      (src_addr == (rev_q ? $past(src_addr) - SRC_AW'(2) : $past(src_addr) + SRC_AW'(4))));

  // R4
  a_r4_dst_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_we && $past(dst_we)) |-> (dst_addr == $past(dst_addr) + MINOR_SH'(4)));

  // R10
  a_r10_drop_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_en |=> !busy);

endmodule

bind modbeat_dma mdm_checker #(.SRC_AW(SRC_AW), .MINOR_SH(MINOR_SH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ch_en    (ch_en),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .src_rd   (src_rd),
  .src_addr (src_addr),
  .dst_we   (dst_we),
  .dst_addr (dst_addr),
  .rev_q    (rev_q)
);

// File: tb/tb_modbeat_dma.sv
`timescale 1ns/1ps
module tb_modbeat_dma;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ch_en;
  logic [15:0] cfg_src;
  logic [19:0] cfg_len;
  logic        cfg_rev;
  logic        req;
  logic        src_rd;
  logic        src_half;
  logic [15:0] src_addr;
  logic [31:0] src_rdata;
  logic        dst_we;
  logic [3:0]  dst_addr;
  logic [31:0] dst_wdata;
  logic        busy;
  logic        done;
  logic        err;

  always #2.5 clk = ~clk;  // 200 MHz

  modbeat_dma dut (
    .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .cfg_src(cfg_src), .cfg_len(cfg_len),
    .cfg_rev(cfg_rev), .req(req), .src_rd(src_rd), .src_half(src_half),
    .src_addr(src_addr), .src_rdata(src_rdata), .dst_we(dst_we), .dst_addr(dst_addr),
    .dst_wdata(dst_wdata), .busy(busy), .done(done), .err(err)
  );

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  int unsigned wr_cnt = 0;
  int unsigned rd_cnt = 0;
  bit          finished = 0;
  logic [7:0]  key = 8'h3C;
  string       cur_tag = "R3";
  logic [3:0]  exp_a[$];
  logic [31:0] exp_d[$];

  // source memory contents, computed rather than stored
  function automatic logic [7:0] mb(input int a);
    int m;
    m = a & 32'hFFFF;
    return 8'(m * 29) ^ 8'(m >> 4) ^ key;
  endfunction
  function automatic logic [31:0] wd(input int a);
    return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)};
  endfunction
  function automatic logic [15:0] hw(input int a);
    return {mb(a + 1), mb(a)};
  endfunction

  always @(posedge clk)
    if (src_rd) src_rdata <= src_half ? {16'h0, hw(int'(src_addr))} : wd(int'(src_addr));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write monitor (R3, R4, R7)
  always @(negedge clk) begin
    if (rst_n && src_rd) rd_cnt++;
    if (rst_n && dst_we) begin
      wr_cnt++;
      if (exp_a.size() == 0) begin
        chk(0, {cur_tag, " unexpected write"}, {28'h0, dst_addr}, 32'hFFFFFFFF);
      end else begin
        logic [3:0]  ea;
        logic [31:0] ed;
        ea = exp_a.pop_front();
        ed = exp_d.pop_front();
        chk(dst_addr == ea, {cur_tag, " dst offset"}, {28'h0, dst_addr}, {28'h0, ea});
        chk(dst_wdata == ed, {cur_tag, " dst data"}, dst_wdata, ed);
      end
    end
  end

  task automatic push_loop(input int base, input bit rev);
    if (!rev) begin
      for (int k = 0; k < 4; k++) begin
        exp_a.push_back(4'(4 * k));
        exp_d.push_back(wd(base + 4 * k));
      end
    end else begin
      for (int k = 3; k >= 0; k--) begin
        exp_a.push_back(4'(4 * k));
        exp_d.push_back({hw(base + 4 * k), hw(base + 4 * k + 2)});
      end
    end
  endtask

  task automatic enable(input int base, input int len, input bit rev);
    @(negedge clk);
    ch_en   = 1'b0;
    cfg_src = 16'(base);
    cfg_len = 20'(len);
    cfg_rev = rev;
    @(negedge clk);
    ch_en = 1'b1;
    @(negedge clk);
  endtask

  // one minor loop; checks the first read in the cycle after the request is sampled
  task automatic do_req(input int base, input bit rev, input string tag);
    int first;
    cur_tag = tag;
    push_loop(base, rev);
    first = rev ? base + 14 : base;
    @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    chk(src_rd && (src_half == rev) && (src_addr == 16'(first)),
        {tag, " first read"}, {15'h0, src_rd, src_addr}, {16'h1, 16'(first)});
    repeat (rev ? 9 : 5) @(negedge clk);
  endtask

  task automatic run_xfer(input int base, input int nloops, input bit rev, input string tag);
    enable(base, nloops * 16, rev);
    for (int m = 0; m < nloops; m++) begin
      if (m == nloops - 1)
        chk(!done, {tag, " R6 done low before last loop"}, {31'h0, done}, 32'h0);
      do_req(base + 16 * m, rev, tag);
    end
    chk(done && !busy, {tag, " R6 done after last loop"}, {30'h0, done, busy}, 32'h2);
    chk(exp_a.size() == 0, {tag, " R3 all writes seen"}, exp_a.size(), 32'h0);
  endtask

  initial begin
    int r0, w0;
    void'($urandom(32'd1234));
    rst_n = 1'b0; ch_en = 1'b0; req = 1'b0;
    cfg_src = '0; cfg_len = '0; cfg_rev = 1'b0; src_rdata = '0;
    repeat (4) @(negedge clk);
    chk({busy, done, err, src_rd, dst_we} == 5'b0, "R1 during reset", {27'h0, busy, done, err, src_rd, dst_we}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, done, err, src_rd, dst_we} == 5'b0, "R1 after reset", {27'h0, busy, done, err, src_rd, dst_we}, 32'h0);

    // R2 armed but quiet
    enable(32'h100, 48, 1'b0);
    r0 = rd_cnt;
    repeat (6) @(negedge clk);
    chk(rd_cnt == r0 && !busy && !done && !err, "R2 armed without request", rd_cnt - r0, 32'h0);
    // R3 R4 R5 forward, three loops (R6 count)
    for (int m = 0; m < 3; m++) begin
      if (m == 2) chk(!done, "R6 done low before last loop", {31'h0, done}, 32'h0);
      do_req(32'h100 + 16 * m, 1'b0, "R3 R4 R5 forward");
    end
    chk(done && !busy, "R6 done after 3 loops", {30'h0, done, busy}, 32'h2);
    r0 = rd_cnt;
    @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    chk(rd_cnt == r0 && done, "R6 request after done ignored", rd_cnt - r0, 32'h0);

    // R7 reverse, two loops (reverse wrap 0 -> 12 in R4)
    run_xfer(32'h200, 2, 1'b1, "R7 R4 reverse");

    // R8 request while busy
    enable(32'h300, 32, 1'b0);
    cur_tag = "R8 busy request";
    push_loop(32'h300, 1'b0);
    w0 = wr_cnt;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    @(negedge clk); req = 1'b1;  // busy here
    @(negedge clk); req = 1'b0;
    repeat (6) @(negedge clk);
    chk(wr_cnt - w0 == 4 && !done && !busy, "R8 busy request ignored", wr_cnt - w0, 32'd4);
    do_req(32'h310, 1'b0, "R8 second loop");
    chk(done, "R8 count not consumed", {31'h0, done}, 32'h1);

    // R9 illegal lengths
    enable(32'h40, 20, 1'b0);
    chk(err && !busy, "R9 length 20 rejected", {30'h0, err, busy}, 32'h2);
    r0 = rd_cnt;
    @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    chk(rd_cnt == r0 && !done, "R9 request ignored on error", rd_cnt - r0, 32'h0);
    enable(32'h40, 0, 1'b0);
    chk(err, "R9 length 0 rejected", {31'h0, err}, 32'h1);
    enable(32'h40, 16, 1'b0);
    chk(!err, "R9 valid enable clears error", {31'h0, err}, 32'h0);

    // R10 abandon mid-loop, then reload
    enable(32'h400, 64, 1'b0);
    w0 = wr_cnt; r0 = rd_cnt;
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0; ch_en = 1'b0;
    repeat (4) @(negedge clk);
    chk(wr_cnt == w0 && rd_cnt - r0 == 1 && !busy, "R10 abandon stops loop",
        {wr_cnt - w0, rd_cnt - r0}, 32'h1);
    run_xfer(32'h500, 1, 1'b1, "R10 reload");

    // random mix
    for (int it = 0; it < 12; it++) begin
      int b, n;
      bit rv;
      key = 8'($urandom);
      b  = int'($urandom % 3000) * 4;
      n  = int'($urandom % 4) + 1;
      rv = 1'($urandom);
      run_xfer(b, n, rv, rv ? "R7 random" : "R3 random");
    end

    // R6 large count: 153600 bytes = 9600 loops
    key = 8'hA5;
    enable(0, 153600, 1'b0);
    for (int m = 0; m < 9600; m++) begin
      if (m == 9599) chk(!done, "R6 large done low before last", {31'h0, done}, 32'h0);
      do_req(16 * m, 1'b0, "R6 large");
    end
    chk(done && !busy, "R6 large done", {30'h0, done, busy}, 32'h2);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R6 actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule